// File: doc/BRIEF.md
# Host Stream Link Controller

This block sits between a host-side word stream and an on-chip learning engine. Every word the host sends carries a two-bit kind tag that marks it as data, configuration, start or command. A control state machine walks a fixed session order. It takes a configuration word that states how many training words follow, and it queues exactly that many data words in an inbound FIFO. It then flags that configuration is complete and waits for a start word. After that it accepts commands one at a time. For each command it pulses a start strobe to the engine and waits for the engine's done pulse. It then announces completion, holds a register-read phase for one cycle, and raises a transfer request while the outbound FIFO still holds results.

The engine pops training words from the inbound FIFO and pushes results into the outbound FIFO. The host drains results through a valid/ready port at up to one word per clock. A small address-selected read port exposes the phase, the FIFO flags, the occupancy counts, a sticky protocol-error bit and the last accepted command.

Top module: `host_link_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the phase to configuration (code 0), empties both FIFOs, clears the error bit and drives `cfg_done`, `eng_start`, `over` and `xfer_req` low.
- R2: Host word kinds are 0 = data, 1 = configuration, 2 = start, 3 = command. `h_in_ready` equals "inbound FIFO not full". A word is taken on a clock edge where both valid and ready are high.
- R3: Each FIFO holds DEPTH (default 1024) words of 32 bits in first-in first-out order. A push to a full FIFO or a pop from an empty FIFO is ignored and leaves contents and count unchanged.
- R4: In phase 0, a configuration word sets the expected data count from its bits [10:0] and moves to phase 1 (data); a count of zero skips to phase 2. In phase 1 each data word is pushed into the inbound FIFO. The edge that takes the last expected word enters phase 2, where `cfg_done` is high for exactly one cycle, and phase 3 follows. Data words outside phase 1 are dropped.
- R5: A start word in phase 3 moves to phase 4 (wait for command). A command word in phase 4 is latched, and for the next single cycle (phase 5) `eng_start` is high with `eng_cmd` equal to the command word. Phase 6 (run) follows.
- R6: A command word taken in any phase other than 4 is discarded without a phase change and sets the error bit (status word 0, bit 4). Only reset clears that bit.
- R7: `eng_done` in phase 6 leads to phase 7, where `over` is high for one cycle. Phase 8 (registers readable) lasts one cycle, then phase 9 (transfer). `eng_done` in any other phase is ignored.
- R8: `xfer_req` is high exactly when the phase is 9 and the outbound FIFO is not empty. Phase 9 returns to phase 4 on the edge after the outbound FIFO is seen empty.
- R9: `h_out_valid` is high whenever the outbound FIFO is not empty, and `h_out_data` is its oldest word. With `h_out_ready` held high, one word leaves per clock.
- R10: The status port returns, at `st_addr` 0, {phase in bits [3:0], error bit 4, inbound empty bit 5, inbound full bit 6, outbound empty bit 7, outbound full bit 8}. Address 1 returns the inbound count, address 2 the outbound count and address 3 the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_in_valid | input | 1 | Host word valid |
| h_in_kind | input | 2 | Host word kind tag |
| h_in_data | input | 32 | Host word payload |
| h_in_ready | output | 1 | Block can take a host word |
| h_out_valid | output | 1 | Result word available |
| h_out_data | output | 32 | Oldest result word |
| h_out_ready | input | 1 | Host takes the result word |
| eng_rd_en | input | 1 | Engine pops the inbound FIFO |
| eng_rd_data | output | 32 | Oldest inbound word |
| eng_rd_empty | output | 1 | Inbound FIFO empty |
| eng_wr_en | input | 1 | Engine pushes a result |
| eng_wr_data | input | 32 | Result word |
| eng_wr_full | output | 1 | Outbound FIFO full |
| eng_start | output | 1 | One-cycle start strobe |
| eng_cmd | output | 32 | Command for the engine |
| eng_done | input | 1 | Engine completion pulse |
| cfg_done | output | 1 | Configuration complete strobe |
| over | output | 1 | Completion strobe toward the host |
| xfer_req | output | 1 | Result transfer request |
| st_addr | input | 2 | Status register select |
| st_rdata | output | 32 | Status register value |

## Verification
The session is driven in its legal order and also with stray words: data words before configuration, and a command before start. These show whether the phase machine filters by kind and phase or simply consumes words. Results are drained first with the host stalled and then at full rate, so that the transfer request's dependence on occupancy is visible apart from the phase. A burst of more than DEPTH results and a fill of the inbound FIFO to capacity show whether overflow is ignored without disturbing order. An engine done pulse outside the run phase shows whether completion is qualified by phase.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;
  typedef enum logic [3:0] {
    PH_CFG    = 4'd0,
    PH_DATA   = 4'd1,
    PH_CFGACK = 4'd2,
    PH_WSTART = 4'd3,
    PH_WCMD   = 4'd4,
    PH_CMD    = 4'd5,
    PH_RUN    = 4'd6,
    PH_OVER   = 4'd7,
    PH_REGS   = 4'd8,
    PH_XFER   = 4'd9
  } phase_e;

  localparam logic [1:0] K_DATA  = 2'd0;
  localparam logic [1:0] K_CFG   = 2'd1;
  localparam logic [1:0] K_START = 2'd2;
  localparam logic [1:0] K_CMD   = 2'd3;

  // Status word 0 layout: phase, error, then the four FIFO flags.
  function automatic logic [8:0] pack_status(input phase_e ph, input logic err,
                                             input logic in_e, input logic in_f,
                                             input logic out_e, input logic out_f);
    return {out_f, out_e, in_f, in_e, err, ph};
  endfunction
endpackage

// File: rtl/hlc_fifo.sv
`timescale 1ns/1ps
module hlc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hlc_fsm.sv
`timescale 1ns/1ps
module hlc_fsm
  import hlc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_fire,
  input  logic [1:0]        word_kind,
  input  logic [DATA_W-1:0] word_data,
  input  logic              eng_done,
  input  logic              out_empty,
  output phase_e            phase,
  output logic              data_push,
  output logic              err,
  output logic              cfg_done,
  output logic              eng_start,
  output logic              over,
  output logic              xfer_req,
  output logic [DATA_W-1:0] cmd_q
);
  logic [CNT_W-1:0] target, got;
  logic [CNT_W-1:0] got_next;
  logic             cmd_fire;

  assign cmd_fire  = word_fire && (word_kind == K_CMD);
  assign data_push = word_fire && (word_kind == K_DATA) && (phase == PH_DATA);
  assign got_next  = got + CNT_W'(1);

  assign cfg_done  = (phase == PH_CFGACK);
  assign eng_start = (phase == PH_CMD);
  assign over      = (phase == PH_OVER);
  assign xfer_req  = (phase == PH_XFER) && !out_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_CFG;
      err    <= 1'b0;
      target <= '0;
      got    <= '0;
      cmd_q  <= '0;
    end else begin
      if (cmd_fire && phase != PH_WCMD) err <= 1'b1;
      case (phase)
        PH_CFG: if (word_fire && word_kind == K_CFG) begin
          target <= word_data[CNT_W-1:0];
          got    <= '0;
          phase  <= (word_data[CNT_W-1:0] == '0) ? PH_CFGACK : PH_DATA;
        end
        PH_DATA: if (data_push) begin
          got <= got_next;
          if (got_next == target) phase <= PH_CFGACK;
        end
        PH_CFGACK: phase <= PH_WSTART;
        PH_WSTART: if (word_fire && word_kind == K_START) phase <= PH_WCMD;
        PH_WCMD: if (cmd_fire) begin
          cmd_q <= word_data;
          phase <= PH_CMD;
        end
        PH_CMD:  phase <= PH_RUN;
        PH_RUN:  if (eng_done) phase <= PH_OVER;
        PH_OVER: phase <= PH_REGS;
        PH_REGS: phase <= PH_XFER;
        PH_XFER: if (out_empty) phase <= PH_WCMD;
        default: phase <= PH_CFG;
      endcase
    end
  end
endmodule

// File: rtl/hlc_status.sv
`timescale 1ns/1ps
module hlc_status
  import hlc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = 11
) (
  input  logic [1:0]        addr,
  input  phase_e            phase,
  input  logic              err,
  input  logic              in_empty,
  input  logic              in_full,
  input  logic              out_empty,
  input  logic              out_full,
  input  logic [CW-1:0]     in_count,
  input  logic [CW-1:0]     out_count,
  input  logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    case (addr)
      2'd0:    rdata = DATA_W'(pack_status(phase, err, in_empty, in_full, out_empty, out_full));
      2'd1:    rdata = DATA_W'(in_count);
      2'd2:    rdata = DATA_W'(out_count);
      default: rdata = cmd_q;
    endcase
  end
endmodule

// File: rtl/host_link_ctrl.sv
`timescale 1ns/1ps
module host_link_ctrl
  import hlc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int CNT_W  = 11,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_in_valid,
  input  logic [1:0]        h_in_kind,
  input  logic [DATA_W-1:0] h_in_data,
  output logic              h_in_ready,
  output logic              h_out_valid,
  output logic [DATA_W-1:0] h_out_data,
  input  logic              h_out_ready,
  input  logic              eng_rd_en,
  output logic [DATA_W-1:0] eng_rd_data,
  output logic              eng_rd_empty,
  input  logic              eng_wr_en,
  input  logic [DATA_W-1:0] eng_wr_data,
  output logic              eng_wr_full,
  output logic              eng_start,
  output logic [DATA_W-1:0] eng_cmd,
  input  logic              eng_done,
  output logic              cfg_done,
  output logic              over,
  output logic              xfer_req,
  input  logic [1:0]        st_addr,
  output logic [DATA_W-1:0] st_rdata
);
  // Named internal events for the checker.
  phase_e        phase;
  logic          word_fire, data_push, err;
  logic          in_full, in_empty, out_full, out_empty;
  logic [CW-1:0] in_count, out_count;
  logic          in_push_ok, in_pop_ok, out_push_ok, out_pop_ok;
  logic          out_pop;

  assign h_in_ready   = !in_full;
  assign word_fire    = h_in_valid && h_in_ready;
  assign out_pop      = h_out_ready;
  assign h_out_valid  = !out_empty;
  assign eng_rd_empty = in_empty;
  assign eng_wr_full  = out_full;

  hlc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_in_fifo (
    .clk(clk), .rst(rst), .push(data_push), .wdata(h_in_data),
    .pop(eng_rd_en), .rdata(eng_rd_data), .full(in_full), .empty(in_empty),
    .count(in_count), .push_ok(in_push_ok), .pop_ok(in_pop_ok)
  );

  hlc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_out_fifo (
    .clk(clk), .rst(rst), .push(eng_wr_en), .wdata(eng_wr_data),
    .pop(out_pop), .rdata(h_out_data), .full(out_full), .empty(out_empty),
    .count(out_count), .push_ok(out_push_ok), .pop_ok(out_pop_ok)
  );

  hlc_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .word_fire(word_fire), .word_kind(h_in_kind),
    .word_data(h_in_data), .eng_done(eng_done), .out_empty(out_empty),
    .phase(phase), .data_push(data_push), .err(err), .cfg_done(cfg_done),
    .eng_start(eng_start), .over(over), .xfer_req(xfer_req), .cmd_q(eng_cmd)
  );

  hlc_status #(.DATA_W(DATA_W), .CW(CW)) u_status (
    .addr(st_addr), .phase(phase), .err(err), .in_empty(in_empty),
    .in_full(in_full), .out_empty(out_empty), .out_full(out_full),
    .in_count(in_count), .out_count(out_count), .cmd_q(eng_cmd),
    .rdata(st_rdata)
  );
endmodule

// File: rtl/hlc_checker.sv
`timescale 1ns/1ps
module hlc_checker #(
  parameter int DEPTH = 1024,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    phase,
  input logic          err,
  input logic [CW-1:0] in_count,
  input logic [CW-1:0] out_count,
  input logic          in_full,
  input logic          out_empty,
  input logic          eng_rd_en,
  input logic          eng_wr_en,
  input logic          out_pop_ok,
  input logic          cfg_done,
  input logic          eng_start,
  input logic          over,
  input logic          xfer_req
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (phase == 4'd0 && in_count == '0 && out_count == '0 && !err));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (in_full && !eng_rd_en) |=> (in_count == $past(in_count)));

  assert_out_bound_R3: assert property (@(posedge clk) disable iff (rst)
    out_count <= CW'(DEPTH));

  assert_cfg_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> (!cfg_done && phase == 4'd3));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> (!eng_start && phase == 4'd6));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_over_next_R7: assert property (@(posedge clk) disable iff (rst)
    over |=> (phase == 4'd8));

  assert_xfer_valid_R8: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (!out_empty && phase == 4'd9));

  assert_drain_rate_R9: assert property (@(posedge clk) disable iff (rst)
    (out_pop_ok && !eng_wr_en) |=> (out_count == $past(out_count) - CW'(1)));
endmodule

bind host_link_ctrl hlc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .phase(phase), .err(err), .in_count(in_count),
  .out_count(out_count), .in_full(in_full), .out_empty(out_empty),
  .eng_rd_en(eng_rd_en), .eng_wr_en(eng_wr_en), .out_pop_ok(out_pop_ok),
  .cfg_done(cfg_done), .eng_start(eng_start), .over(over), .xfer_req(xfer_req)
);

// File: tb/host_link_ctrl_test.sv
`timescale 1ns/1ps
module host_link_ctrl_test;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_in_valid = 1'b0;
  logic [1:0]  h_in_kind = 2'd0;
  logic [31:0] h_in_data = '0;
  logic        h_in_ready;
  logic        h_out_valid;
  logic [31:0] h_out_data;
  logic        h_out_ready = 1'b0;
  logic        eng_rd_en = 1'b0;
  logic [31:0] eng_rd_data;
  logic        eng_rd_empty;
  logic        eng_wr_en = 1'b0;
  logic [31:0] eng_wr_data = '0;
  logic        eng_wr_full;
  logic        eng_start;
  logic [31:0] eng_cmd;
  logic        eng_done = 1'b0;
  logic        cfg_done;
  logic        over;
  logic        xfer_req;
  logic [1:0]  st_addr = 2'd0;
  logic [31:0] st_rdata;

  int checks = 0;
  int errors = 0;
  int popped = 0;
  bit finished = 0;
  logic [31:0] sb_q[$];

  always #2 clk = ~clk;

  host_link_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic status(input logic [1:0] a, output logic [31:0] v);
    st_addr = a; #0.1; v = st_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  // Driver: send one host word, waiting for ready.
  task automatic send(input logic [1:0] k, input logic [31:0] d);
    h_in_valid = 1'b1; h_in_kind = k; h_in_data = d;
    @(negedge clk);
    while (!h_in_ready) @(negedge clk);
    @(posedge clk); #1;
    h_in_valid = 1'b0;
  endtask

  // Engine result push; also feeds the scoreboard when room remains.
  task automatic eng_push(input logic [31:0] d);
    if (sb_q.size() + popped < 1 || !eng_wr_full) begin end
    if (!eng_wr_full) sb_q.push_back(d);
    eng_wr_en = 1'b1; eng_wr_data = d; tick(); eng_wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; tick(); eng_done = 1'b0;
  endtask

  // Monitor: compare each drained result with the scoreboard.
  always @(negedge clk) begin
    if (!rst && h_out_valid && h_out_ready) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9: actual %h expected <none>", h_out_data);
      end else begin
        logic [31:0] e;
        e = sb_q.pop_front();
        if (h_out_data !== e) begin
          errors++;
          $display("FAIL R9: actual %h expected %h", h_out_data, e);
        end
      end
      popped++;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state, R10 status layout
    status(2'd0, v); chk("R1 status0", v, 32'h0A0);
    chk("R1 xfer_req", {31'd0, xfer_req}, 32'd0);
    chk("R1 strobes", {29'd0, cfg_done, eng_start, over}, 32'd0);
    chk("R2 ready after reset", {31'd0, h_in_ready}, 32'd1);

    // R4 data before configuration is dropped; R3 pop from empty ignored
    send(2'd0, 32'h111);
    eng_rd_en = 1'b1; tick(); eng_rd_en = 1'b0;
    status(2'd1, v); chk("R4 stray data dropped", v, 32'd0);
    status(2'd0, v); chk("R3 underflow ignored", v, 32'h0A0);

    // R4 configuration and data phase
    send(2'd1, 32'd3);
    status(2'd0, v); chk("R4 phase data", v[3:0], 32'd1);
    send(2'd0, 32'hA1); send(2'd0, 32'hA2); send(2'd0, 32'hA3);
    chk("R4 cfg_done high", {31'd0, cfg_done}, 32'd1);
    tick();
    chk("R4 cfg_done one cycle", {31'd0, cfg_done}, 32'd0);
    status(2'd0, v); chk("R4 phase wait start", v[3:0], 32'd3);
    status(2'd1, v); chk("R10 inbound count", v, 32'd3);

    // R6 command before start
    send(2'd3, 32'h77);
    status(2'd0, v); chk("R6 err set", v[4], 32'd1);
    chk("R6 phase unchanged", v[3:0], 32'd3);

    // R5 start then command
    send(2'd2, 32'h0);
    status(2'd0, v); chk("R5 phase wait cmd", v[3:0], 32'd4);
    send(2'd3, 32'h5A);
    chk("R5 eng_start", {31'd0, eng_start}, 32'd1);
    chk("R5 eng_cmd", eng_cmd, 32'h5A);
    status(2'd3, v); chk("R10 last cmd", v, 32'h5A);
    tick();
    chk("R5 start one cycle", {31'd0, eng_start}, 32'd0);
    status(2'd0, v); chk("R5 phase run", v[3:0], 32'd6);

    // R3 inbound order
    for (int i = 0; i < 3; i++) begin
      chk("R3 inbound order", eng_rd_data, 32'hA1 + 32'(i));
      eng_rd_en = 1'b1; tick(); eng_rd_en = 1'b0;
    end
    chk("R3 inbound empty", {31'd0, eng_rd_empty}, 32'd1);

    // Results with host stalled
    for (int i = 0; i < 4; i++) eng_push(32'hC000 + 32'(i));
    status(2'd2, v); chk("R10 outbound count", v, 32'd4);
    chk("R8 no request in run", {31'd0, xfer_req}, 32'd0);
    chk("R9 valid when nonempty", {31'd0, h_out_valid}, 32'd1);

    // R7 completion sequence
    pulse_done();
    chk("R7 over", {31'd0, over}, 32'd1);
    tick();
    chk("R7 over one cycle", {31'd0, over}, 32'd0);
    status(2'd0, v); chk("R7 phase regs", v[3:0], 32'd8);
    tick();
    chk("R8 request raised", {31'd0, xfer_req}, 32'd1);
    status(2'd0, v); chk("R6 err sticky", v[4], 32'd1);

    // R9 full-rate drain
    h_out_ready = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R9 drained in 4 cycles", {31'd0, h_out_valid}, 32'd0);
    chk("R8 request cleared", {31'd0, xfer_req}, 32'd0);
    tick();
    h_out_ready = 1'b0;
    status(2'd0, v); chk("R8 back to wait cmd", v[3:0], 32'd4);
    chk("R9 scoreboard empty", 32'(sb_q.size()), 32'd0);

    // R7 done outside run is ignored
    pulse_done();
    status(2'd0, v); chk("R7 stray done", v[3:0], 32'd4);
    chk("R7 no over", {31'd0, over}, 32'd0);

    // R3 outbound overflow
    send(2'd3, 32'h33); tick();
    popped = 0;
    for (int i = 0; i < DEPTH + 6; i++) eng_push(32'h10000 + 32'(i));
    status(2'd2, v); chk("R3 outbound capped", v, 32'(DEPTH));
    status(2'd0, v); chk("R3 outbound full flag", v[8], 32'd1);
    pulse_done(); tick(); tick();
    h_out_ready = 1'b1;
    for (int i = 0; i < DEPTH + 20 && h_out_valid; i++) tick();
    h_out_ready = 1'b0;
    chk("R3 outbound words drained", 32'(popped), 32'(DEPTH));
    chk("R3 scoreboard empty", 32'(sb_q.size()), 32'd0);

    // R1 reset from a busy state
    do_reset();
    status(2'd0, v); chk("R1 reset clears err", v, 32'h0A0);

    // R2/R3 inbound fill
    send(2'd1, 32'd1100);
    for (int i = 0; i < DEPTH; i++) send(2'd0, 32'(i));
    chk("R2 ready low when full", {31'd0, h_in_ready}, 32'd0);
    status(2'd0, v); chk("R3 inbound full flag", v[6], 32'd1);
    h_in_valid = 1'b1; h_in_kind = 2'd0; h_in_data = 32'hDEAD; tick(); h_in_valid = 1'b0;
    status(2'd1, v); chk("R3 inbound capped", v, 32'(DEPTH));
    chk("R3 inbound head intact", eng_rd_data, 32'd0);

    do_reset();
    status(2'd1, v); chk("R1 inbound emptied", v, 32'd0);
    status(2'd0, v); chk("R1 phase config", v[3:0], 32'd0);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule